// File: doc/BRIEF.md
# Programmable Colour Bar Generator

This block sits in the luma/chroma path of a video encoder. It can replace the incoming byte-multiplexed 4:2:2 stream with a test pattern of eight vertical bars. The colour of each bar is not fixed. It is read from an eight-slot colour table, and each slot holds a luma byte and two chroma bytes. Slot 0 paints the leftmost bar and slot 7 the rightmost, so software can load any eight colours. Examples are a standard bar chart, a grey ramp or a single flat field.

A single register-style write port loads the table and also sets the mode bit. No pin or external data source can turn the pattern on; only the mode bit does. After reset the mode bit selects pass-through, and the input stream is copied to the output with one cycle of latency. With the mode bit set, the block works as follows:
- It counts active bytes from each line-start pulse.
- It maps them to pixels and bars.
- It emits Cb, Y, Cr, Y bytes taken from the table.
- Outside the active window it emits blanking levels.

Top module: `colour_bar_gen`

## Requirements
- R1: After reset `pix_o` is 0, the mode bit selects pass-through, and every table slot holds black: luma 16, Cb 128, Cr 128.
- R2: While the mode bit is 0, `pix_o` equals the `pix_i` value of the previous cycle. This holds in every cycle, whatever the strobes and table contents.
- R3: When `cfg_we_i` is high, the write is stored at the clock edge. `cfg_field_i` selects what is written: 0 writes the luma byte of slot `cfg_slot_i`, 1 writes its Cb byte, 2 writes its Cr byte, and 3 writes the mode bit from `cfg_data_i[0]` (1 = bars).
- R4: A line has 720 active pixels carried in 1440 active bytes. The byte index k is the number of `active_i` cycles since the last `line_start_i`. A cycle with `line_start_i` high has k = 0, even when `active_i` is high in the same cycle.
- R5: The line is split into 8 bars of 90 pixels each. Bar b covers pixels 90·b to 90·b+89 and uses table slot b, in ascending order.
- R6: In bar mode, k mod 4 selects the byte: 0 = Cb, 1 = Y, 2 = Cr, 3 = Y. Y uses the bar of pixel k/2. Cb and Cr use the bar of the even pixel 2·(k/4).
- R7: In bar mode, cycles without `active_i` output blanking bytes. The value is 128 when a blank-phase bit is 0 and 16 when it is 1. The bit is cleared by `line_start_i` and toggles after every inactive cycle.
- R8: A table write takes effect for the byte presented in the cycle after the write. The byte presented in the same cycle as the write still sees the old value.
- R9: `line_start_i` restarts the byte index at 0 even in the middle of a line, so the next line begins again with slot 0.
- R10: Active bytes beyond 1440 in one line keep using slot 7, while the Cb/Y/Cr/Y order continues.
- R11: Every output byte appears one cycle after the inputs it is computed from. A mode write affects the byte presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_start_i | input | 1 | One-cycle pulse marking the start of a line |
| active_i | input | 1 | High for each active-video byte |
| pix_i | input | 8 | Pass-through multiplexed 4:2:2 stream |
| cfg_we_i | input | 1 | Write strobe for table and mode |
| cfg_field_i | input | 2 | Write target: 0 luma, 1 Cb, 2 Cr, 3 mode |
| cfg_slot_i | input | 3 | Table slot written |
| cfg_data_i | input | 8 | Write data |
| pix_o | output | 8 | Registered multiplexed 4:2:2 output |

## Verification
The byte counter can go wrong: a wrong count, a missed restart or a bad saturation. Any of these faults moves a bar edge. It shows at `pix_o` within one byte of the first bar boundary it disturbs, or at the first byte of the next line. A swapped byte phase gives luma where chroma is expected within four cycles of the start of active video. A corrupted table slot appears only while its bar is on screen, so every slot is loaded with a distinct value and a whole line is compared. The blank-phase bit shows its state in the first inactive byte after each line start and after each active window.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

  typedef enum logic [1:0] {
    FLD_LUMA = 2'd0,
    FLD_CB   = 2'd1,
    FLD_CR   = 2'd2,
    FLD_MODE = 2'd3
  } cfg_field_e;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } byte_phase_e;

  // bar number of a pixel, clamped to the last bar
  function automatic int unsigned bar_of(input int unsigned pix,
                                         input int unsigned bar_w,
                                         input int unsigned n_bars);
    int unsigned q;
    q = pix / bar_w;
    if (q >= n_bars) q = n_bars - 1;
    return q;
  endfunction

  // pixel whose luma a byte carries
  function automatic int unsigned luma_pixel(input int unsigned byte_idx);
    return byte_idx >> 1;
  endfunction

  // even pixel whose chroma pair a byte carries
  function automatic int unsigned chroma_pixel(input int unsigned byte_idx);
    return (byte_idx >> 2) << 1;
  endfunction

endpackage

// File: rtl/cbar_table.sv
module cbar_table #(
  parameter int DW    = 8,
  parameter int BARS  = 8,
  parameter int IDX_W = $clog2(BARS),
  parameter logic [DW-1:0] BLANK_Y = DW'(16),
  parameter logic [DW-1:0] BLANK_C = DW'(128)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_field_i,
  input  logic [IDX_W-1:0] cfg_slot_i,
  input  logic [DW-1:0]    cfg_data_i,
  input  logic [IDX_W-1:0] y_slot_i,
  input  logic [IDX_W-1:0] c_slot_i,
  output logic [DW-1:0]    y_o,
  output logic [DW-1:0]    cb_o,
  output logic [DW-1:0]    cr_o,
  output logic             bar_en_o
);
  import cbar_pkg::*;

  logic [BARS-1:0][DW-1:0] ytab;
  logic [BARS-1:0][DW-1:0] cbtab;
  logic [BARS-1:0][DW-1:0] crtab;
  logic                    mode_q;
  cfg_field_e              field;

  assign field = cfg_field_e'(cfg_field_i);

  for (genvar e = 0; e < BARS; e++) begin : g_slot
    logic [DW-1:0] y_q, cb_q, cr_q;
    logic          hit;
    assign hit = cfg_we_i && (cfg_slot_i == IDX_W'(e));
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        y_q  <= BLANK_Y;
        cb_q <= BLANK_C;
        cr_q <= BLANK_C;
      end else if (hit) begin
        case (field)
          FLD_LUMA: y_q  <= cfg_data_i;
          FLD_CB:   cb_q <= cfg_data_i;
          FLD_CR:   cr_q <= cfg_data_i;
          default:  ;
        endcase
      end
    end
    assign ytab[e]  = y_q;
    assign cbtab[e] = cb_q;
    assign crtab[e] = cr_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= 1'b0;
    else if (cfg_we_i && field == FLD_MODE) mode_q <= cfg_data_i[0];
  end

  assign y_o      = ytab[y_slot_i];
  assign cb_o     = cbtab[c_slot_i];
  assign cr_o     = crtab[c_slot_i];
  assign bar_en_o = mode_q;

  // R3
  luma_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_field_i == 2'd0) |=> ytab[$past(cfg_slot_i)] == $past(cfg_data_i));

  // R3
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_field_i == 2'd3) |=> $stable(mode_q));

endmodule

// File: rtl/cbar_pos.sv
module cbar_pos #(
  parameter int PIX   = 720,
  parameter int BARS  = 8,
  parameter int IDX_W = $clog2(BARS),
  parameter int CNT_W = $clog2(4 * PIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic             active_i,
  output logic [1:0]       phase_o,
  output logic [IDX_W-1:0] y_slot_o,
  output logic [IDX_W-1:0] c_slot_o,
  output logic             blank_luma_o
);
  import cbar_pkg::*;

  localparam int BAR_W = PIX / BARS;

  logic [CNT_W-1:0] cnt_q, idx_now, cnt_d;
  logic             bph_q, bph_now, bph_d;

  assign idx_now = line_start_i ? '0 : cnt_q;
  assign cnt_d   = (active_i && idx_now != {CNT_W{1'b1}}) ? idx_now + 1'b1 : idx_now;
  assign bph_now = line_start_i ? 1'b0 : bph_q;
  assign bph_d   = active_i ? bph_now : ~bph_now;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bph_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bph_q <= bph_d;
    end
  end

  assign phase_o      = idx_now[1:0];
  assign y_slot_o     = IDX_W'(bar_of(luma_pixel(32'(idx_now)), BAR_W, BARS));
  assign c_slot_o     = IDX_W'(bar_of(chroma_pixel(32'(idx_now)), BAR_W, BARS));
  assign blank_luma_o = bph_now;

  // R4
  first_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && active_i) |=> cnt_q == CNT_W'(1));

  // R9
  count_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> cnt_q >= $past(cnt_q));

  // R7
  blank_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> bph_q != $past(bph_now));

endmodule

// File: rtl/cbar_fmt.sv
module cbar_fmt #(
  parameter int DW = 8,
  parameter logic [DW-1:0] BLANK_Y = DW'(16),
  parameter logic [DW-1:0] BLANK_C = DW'(128)
) (
  input  logic          bar_en_i,
  input  logic          active_i,
  input  logic [1:0]    phase_i,
  input  logic          blank_luma_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] cb_i,
  input  logic [DW-1:0] cr_i,
  input  logic [DW-1:0] pix_i,
  output logic [DW-1:0] byte_o
);
  import cbar_pkg::*;

  logic [DW-1:0] bar_byte;

  always_comb begin
    case (byte_phase_e'(phase_i))
      PH_CB:   bar_byte = cb_i;
      PH_CR:   bar_byte = cr_i;
      default: bar_byte = y_i;
    endcase
  end

  always_comb begin
    if (!bar_en_i)      byte_o = pix_i;
    else if (!active_i) byte_o = blank_luma_i ? BLANK_Y : BLANK_C;
    else                byte_o = bar_byte;
  end

endmodule

// File: rtl/colour_bar_gen.sv
module colour_bar_gen #(
  parameter int DW    = 8,
  parameter int PIX   = 720,
  parameter int BARS  = 8,
  parameter int IDX_W = $clog2(BARS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic             active_i,
  input  logic [DW-1:0]    pix_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_field_i,
  input  logic [IDX_W-1:0] cfg_slot_i,
  input  logic [DW-1:0]    cfg_data_i,
  output logic [DW-1:0]    pix_o
);
  localparam logic [DW-1:0] BLANK_Y = DW'(16);
  localparam logic [DW-1:0] BLANK_C = DW'(128);

  logic [1:0]       phase;
  logic [IDX_W-1:0] y_slot, c_slot;
  logic             blank_luma, bar_en;
  logic [DW-1:0]    y_val, cb_val, cr_val, next_byte;

  cbar_pos #(.PIX(PIX), .BARS(BARS), .IDX_W(IDX_W)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .line_start_i(line_start_i), .active_i(active_i),
    .phase_o(phase), .y_slot_o(y_slot), .c_slot_o(c_slot),
    .blank_luma_o(blank_luma)
  );

  cbar_table #(.DW(DW), .BARS(BARS), .IDX_W(IDX_W),
               .BLANK_Y(BLANK_Y), .BLANK_C(BLANK_C)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_field_i(cfg_field_i),
    .cfg_slot_i(cfg_slot_i), .cfg_data_i(cfg_data_i),
    .y_slot_i(y_slot), .c_slot_i(c_slot),
    .y_o(y_val), .cb_o(cb_val), .cr_o(cr_val), .bar_en_o(bar_en)
  );

  cbar_fmt #(.DW(DW), .BLANK_Y(BLANK_Y), .BLANK_C(BLANK_C)) u_fmt (
    .bar_en_i(bar_en), .active_i(active_i), .phase_i(phase),
    .blank_luma_i(blank_luma), .y_i(y_val), .cb_i(cb_val), .cr_i(cr_val),
    .pix_i(pix_i), .byte_o(next_byte)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= next_byte;
  end

  // R2
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bar_en |=> pix_o == $past(pix_i));

  // R7
  blank_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bar_en && !active_i) |=> (pix_o == BLANK_Y || pix_o == BLANK_C));

  // R6
  chroma_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bar_en && active_i && phase == 2'd0) |=> pix_o == $past(cb_val));

endmodule

// File: tb/colour_bar_gen_tb.sv
`timescale 1ns/1ps
module colour_bar_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sol = 1'b0, act = 1'b0, we = 1'b0;
  logic [7:0] vin = 8'h00, wdat = 8'h00;
  logic [1:0] wfld = 2'd0;
  logic [2:0] wslot = 3'd0;
  logic [7:0] pout;

  int checks = 0;
  int errors = 0;

  logic [7:0] my [8];
  logic [7:0] mu [8];
  logic [7:0] mv [8];
  logic       m_mode;
  int         m_k;
  logic       m_b;

  always #2 clk = ~clk;

  colour_bar_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(sol), .active_i(act),
    .pix_i(vin), .cfg_we_i(we), .cfg_field_i(wfld), .cfg_slot_i(wslot),
    .cfg_data_i(wdat), .pix_o(pout)
  );

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int clamp_bar(input int pixel);
    int b = pixel / 90;
    return (b > 7) ? 7 : b;
  endfunction

  function automatic logic [7:0] expect_byte(input logic a, input logic s, input logic [7:0] v);
    int k;
    if (!m_mode) return v;
    if (!a) return ((s ? 1'b0 : m_b) ? 8'd16 : 8'd128);
    k = s ? 0 : m_k;
    case (k % 4)
      0: return mu[clamp_bar(2 * (k / 4))];
      2: return mv[clamp_bar(2 * (k / 4))];
      default: return my[clamp_bar(k / 2)];
    endcase
  endfunction

  task automatic step(input logic a, input logic s, input logic [7:0] v,
                      input logic w, input logic [1:0] f, input logic [2:0] sl,
                      input logic [7:0] d, input string tag);
    logic [7:0] e;
    int kn;
    @(negedge clk);
    act = a; sol = s; vin = v; we = w; wfld = f; wslot = sl; wdat = d;
    e = expect_byte(a, s, v);
    kn = s ? 0 : m_k;
    if (a && kn != 4095) kn++;
    m_k = kn;
    m_b = a ? (s ? 1'b0 : m_b) : ~(s ? 1'b0 : m_b);
    if (w) begin
      case (f)
        2'd0: my[sl] = d;
        2'd1: mu[sl] = d;
        2'd2: mv[sl] = d;
        default: m_mode = d[0];
      endcase
    end
    @(posedge clk);
    #1;
    chk(tag, pout, e);
  endtask

  task automatic cfg(input logic [1:0] f, input logic [2:0] sl, input logic [7:0] d);
    step(1'b0, 1'b0, 8'h00, 1'b1, f, sl, d, "R3 R7 cfg");
  endtask

  task automatic run_line(input int n, input string tag);
    step(1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, "R7 sol blank");
    for (int i = 0; i < n; i++)
      step(1'b1, 1'b0, 8'(i * 3), 1'b0, 2'd0, 3'd0, 8'h00, tag);
    for (int i = 0; i < 4; i++)
      step(1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, "R7 tail blank");
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    m_mode = 1'b0; m_k = 0; m_b = 1'b0;
    for (int i = 0; i < 8; i++) begin my[i] = 8'd16; mu[i] = 8'd128; mv[i] = 8'd128; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset output", pout, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 8'h5A, 1'b0, 2'd0, 3'd0, 8'h00, "R1 R2 default pass-through");
    step(1'b0, 1'b0, 8'hA7, 1'b0, 2'd0, 3'd0, 8'h00, "R1 R2 default pass-through");
    cfg(2'd3, 3'd0, 8'h01);
    run_line(8, "R1 black table");
  endtask

  task automatic t_program_line;
    for (int e = 0; e < 8; e++) begin
      cfg(2'd0, 3'(e), 8'(20 + e * 25));
      cfg(2'd1, 3'(e), 8'(200 - e * 9));
      cfg(2'd2, 3'(e), 8'(40 + e * 17));
    end
    run_line(1440, "R4 R5 R6 full line");
  endtask

  task automatic t_midwrite;
    step(1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, "R7 sol blank");
    for (int i = 0; i < 1440; i++) begin
      if (i == 600)
        step(1'b1, 1'b0, 8'h00, 1'b1, 2'd0, 3'd3, 8'hEE, "R8 write same bar");
      else if (i == 900)
        step(1'b1, 1'b0, 8'h00, 1'b1, 2'd1, 3'd6, 8'h11, "R8 write later bar");
      else
        step(1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, "R8 line after write");
    end
  endtask

  task automatic t_restart;
    step(1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, "R7 sol blank");
    for (int i = 0; i < 300; i++)
      step(1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, "R9 partial line");
    step(1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, "R4 R9 start with active");
    for (int i = 0; i < 200; i++)
      step(1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, "R9 restarted line");
  endtask

  task automatic t_overrun;
    run_line(1452, "R10 overrun");
  endtask

  task automatic t_mode_switch;
    step(1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, "R7 sol blank");
    for (int i = 0; i < 10; i++)
      step(1'b1, 1'b0, 8'h33, 1'b0, 2'd0, 3'd0, 8'h00, "R6 bars before switch");
    step(1'b1, 1'b0, 8'h33, 1'b1, 2'd3, 3'd0, 8'h00, "R11 mode write byte");
    for (int i = 0; i < 10; i++)
      step(1'b1, 1'b0, 8'(i + 1), 1'b0, 2'd0, 3'd0, 8'h00, "R11 R2 after switch");
    step(1'b1, 1'b0, 8'h77, 1'b1, 2'd0, 3'd0, 8'h99, "R2 write in pass-through");
    run_line(200, "R2 pass-through line");
    cfg(2'd3, 3'd0, 8'h01);
    run_line(12, "R3 table kept while off");
  endtask

  initial begin
    t_reset;
    t_program_line;
    t_midwrite;
    t_restart;
    t_overrun;
    t_mode_switch;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule